// File: doc/BRIEF.md
# Reset and Clock Start-Up Sequencer

This block sits between a chip's reset sources and its clock tree. It runs from a fast reference clock, `clk_ref`. Cycle enables for the bus, the CPU and the peripherals are made from it by dividing by four. Six reset causes come in: power-on, a filtered external pin, watchdog, low-voltage, illegal opcode and illegal address. The block turns them into a single internal reset. While that reset is active, every clock enable is held off until a 12-bit timeout counter reaches its terminal count.

The same counter also times the wake-up from stop mode. A configuration input picks a short or a long delay. In wait mode only the CPU enable is gated. A sticky status word records which cause produced the most recent reset. The block also presents the two reset vector byte addresses, which depend on whether the chip is in monitor mode.

Top module: `sysinit_ctrl`

## Requirements
- R1: `bus_ce` pulses only in the run phase. It pulses on every fourth `clk_ref` cycle, and the first pulse comes on the fourth cycle of the run phase. `per_ce` always equals `bus_ce`.
- R2: While `por_req` is high, `int_rst` is 1 and all enables are 0. After `por_req` falls, `int_rst` stays 1 for exactly 4096 rising edges and then falls.
- R3: Any of `wdog_rst`, `lvd_rst`, `bad_op_rst` or `bad_addr_rst` sampled high sets `int_rst` at the next edge and clears the timeout counter. `int_rst` falls 4096 edges after the last edge at which such a source was sampled high.
- R4: The pin reset fires only when `pin_rst_en` is 1 and the synchronised `ext_rst_n` has been low for `PIN_MIN_LOW` (default 67) consecutive cycles. Shorter low pulses, and any pulse while `pin_rst_en` is 0, have no effect. A pin reset does not clear the counter. It ends at the first terminal count (counter value 4095) reached while the pin is no longer held low.
- R5: `stop_req` in the run phase enters stop. In stop, all enables and `int_rst` are 0. `wake_irq` in stop clears the counter. The run phase then resumes after 32 edges if `stop_short` is 1, or 4096 edges if it is 0. The first `bus_ce` follows three cycles later.
- R6: While `wait_req` is 1, `cpu_ce` is 0 and `per_ce` keeps pulsing.
- R7: `rst_status` has bit 0 for power-on, bit 1 for pin, bit 2 for watchdog, bit 3 for low-voltage, bit 4 for illegal opcode and bit 5 for illegal address. Power-on sets it to 6'b000001. A reset event replaces it with exactly the causes seen in that cycle. In all other cycles it holds its value.
- R8: `vec_hi_addr`/`vec_lo_addr` are 0xFFFE/0xFFFF when `monitor_mode` is 0, and 0xFEFE/0xFEFF when it is 1.
- R9: A reset source takes priority over stop and over the stop-exit delay: it enters the reset hold from either state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_req | input | 1 | Power-on reset, active high, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pin_rst_en | input | 1 | Configuration: honour the reset pin |
| wdog_rst | input | 1 | Watchdog reset request |
| lvd_rst | input | 1 | Low-voltage reset request |
| bad_op_rst | input | 1 | Illegal-opcode reset request |
| bad_addr_rst | input | 1 | Illegal-address reset request |
| stop_req | input | 1 | CPU requests stop mode |
| wake_irq | input | 1 | Interrupt that ends stop mode |
| stop_short | input | 1 | Configuration: 1 selects the short stop-exit delay |
| wait_req | input | 1 | CPU is in wait mode |
| monitor_mode | input | 1 | Selects the monitor reset vector |
| bus_ce | output | 1 | Bus cycle enable |
| cpu_ce | output | 1 | CPU cycle enable |
| per_ce | output | 1 | Peripheral cycle enable |
| int_rst | output | 1 | Internal reset, active high |
| rst_status | output | 6 | Sticky reset cause word |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |

## Verification
On every cycle, the assertions check four things. An internal source must clear the counter, while a pin event must let it advance. Reset release may happen only at the terminal count. The status word may not move without an event. Enables must stay quiet during reset, stop and wait.

The exact lengths of the timeouts need the bench's scenarios to show them: 4096 after power-on or a source, 32 or 4096 after a stop wake. So do the suppression of short or disabled pin pulses and the precise cause recorded for simultaneous sources. The bench's cycle model covers all of these.

// File: rtl/sysinit_pkg.sv
package sysinit_pkg;
  typedef enum logic [1:0] {PH_HOLD, PH_RUN, PH_STOP, PH_SDLY} phase_t;

  localparam int STW      = 6;
  localparam int ST_POR   = 0;
  localparam int ST_PIN   = 1;
  localparam int ST_WDOG  = 2;
  localparam int ST_LVD   = 3;
  localparam int ST_BOP   = 4;
  localparam int ST_BADR  = 5;

  // Vector byte address for the high byte
  function automatic logic [15:0] vec_high(input logic mon);
    return mon ? 16'hFEFE : 16'hFFFE;
  endfunction

  // Vector byte address for the low byte
  function automatic logic [15:0] vec_low(input logic mon);
    return vec_high(mon) + 16'd1;
  endfunction

  // Number of counted cycles in the stop-exit delay
  function automatic int stop_span(input logic short_sel, input int short_n, input int long_n);
    return short_sel ? short_n : long_n;
  endfunction
endpackage

// File: rtl/sysinit_pinflt.sv
module sysinit_pinflt #(
  parameter int MIN_LOW = 67
) (
  input  logic clk_ref,
  input  logic por_req,
  input  logic pin_n,
  input  logic pin_en,
  output logic pin_hold,
  output logic pin_evt
);
  localparam int LW = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [LW-1:0] LAST = LW'(MIN_LOW - 1);

  logic          sync1, sync2;
  logic [LW-1:0] low_cnt;
  logic          hold_q;
  logic          low_now;

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= pin_n;
      sync2 <= sync1;
    end
  end

  assign low_now = ~sync2 & pin_en;

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req)             low_cnt <= '0;
    else if (!low_now)       low_cnt <= '0;
    else if (low_cnt != LAST) low_cnt <= low_cnt + LW'(1);
  end

  assign pin_hold = low_now && (low_cnt == LAST);

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req) hold_q <= 1'b0;
    else         hold_q <= pin_hold;
  end

  assign pin_evt = pin_hold & ~hold_q;
endmodule

// File: rtl/sysinit_busdiv.sv
module sysinit_busdiv #(
  parameter int DIV = 4
) (
  input  logic clk_ref,
  input  logic por_req,
  input  logic run,
  output logic bus_ce
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DEND = DW'(DIV - 1);

  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req)              div_cnt <= '0;
    else if (!run)            div_cnt <= '0;
    else if (div_cnt == DEND) div_cnt <= '0;
    else                      div_cnt <= div_cnt + DW'(1);
  end

  assign bus_ce = run && (div_cnt == DEND);
endmodule

// File: rtl/sysinit_fsm.sv
module sysinit_fsm
  import sysinit_pkg::*;
#(
  parameter int POR_CYC   = 4096,
  parameter int STOP_LONG = 4096,
  parameter int STOP_SHRT = 32,
  localparam int CW = $clog2(POR_CYC)
) (
  input  logic           clk_ref,
  input  logic           por_req,
  input  logic [3:0]     int_src,
  input  logic           pin_hold,
  input  logic           pin_evt,
  input  logic           stop_req,
  input  logic           wake_irq,
  input  logic           stop_short,
  output phase_t         phase,
  output logic [CW-1:0]  tmo_cnt,
  output logic [STW-1:0] rst_status,
  output logic           evt_int
);
  localparam logic [CW-1:0] TC = CW'(POR_CYC - 1);

  logic          stop_wake;
  logic          tmo_done;
  logic          sdly_done;
  logic [CW-1:0] sdly_end;

  assign evt_int   = |int_src;
  assign stop_wake = (phase == PH_STOP) && wake_irq && !pin_evt && !evt_int;
  assign tmo_done  = (tmo_cnt == TC);
  assign sdly_end  = CW'(stop_span(stop_short, STOP_SHRT, STOP_LONG) - 1);
  assign sdly_done = (tmo_cnt == sdly_end);

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req)        tmo_cnt <= '0;
    else if (evt_int)   tmo_cnt <= '0;
    else if (stop_wake) tmo_cnt <= '0;
    else if (tmo_done)  tmo_cnt <= '0;
    else                tmo_cnt <= tmo_cnt + CW'(1);
  end

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req) begin
      phase <= PH_HOLD;
    end else if (evt_int || pin_evt) begin
      phase <= PH_HOLD;
    end else begin
      unique case (phase)
        PH_HOLD: if (tmo_done && !pin_hold) phase <= PH_RUN;
        PH_RUN:  if (stop_req)              phase <= PH_STOP;
        PH_STOP: if (wake_irq)              phase <= PH_SDLY;
        PH_SDLY: if (sdly_done)             phase <= PH_RUN;
        default:                            phase <= PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_ref or posedge por_req) begin
    if (por_req) begin
      rst_status <= STW'(1) << ST_POR;
    end else if (evt_int || pin_evt) begin
      rst_status <= '0;
      rst_status[ST_PIN]  <= pin_evt;
      rst_status[ST_WDOG] <= int_src[0];
      rst_status[ST_LVD]  <= int_src[1];
      rst_status[ST_BOP]  <= int_src[2];
      rst_status[ST_BADR] <= int_src[3];
    end
  end
endmodule

// File: rtl/sysinit_ctrl.sv
module sysinit_ctrl
  import sysinit_pkg::*;
#(
  parameter int POR_CYCLES   = 4096,
  parameter int STOP_LONG    = 4096,
  parameter int STOP_SHORT   = 32,
  parameter int PIN_MIN_LOW  = 67,
  parameter int BUS_DIV      = 4
) (
  input  logic        clk_ref,
  input  logic        por_req,
  input  logic        ext_rst_n,
  input  logic        pin_rst_en,
  input  logic        wdog_rst,
  input  logic        lvd_rst,
  input  logic        bad_op_rst,
  input  logic        bad_addr_rst,
  input  logic        stop_req,
  input  logic        wake_irq,
  input  logic        stop_short,
  input  logic        wait_req,
  input  logic        monitor_mode,
  output logic        bus_ce,
  output logic        cpu_ce,
  output logic        per_ce,
  output logic        int_rst,
  output logic [5:0]  rst_status,
  output logic [15:0] vec_hi_addr,
  output logic [15:0] vec_lo_addr
);
  localparam int CW = $clog2(POR_CYCLES);

  phase_t        phase;
  logic [CW-1:0] tmo_cnt;
  logic          evt_int;
  logic          evt_pin;
  logic          pin_hold;
  logic          in_run;
  logic          in_stop;

  sysinit_pinflt #(.MIN_LOW(PIN_MIN_LOW)) u_pin (
    .clk_ref  (clk_ref),
    .por_req  (por_req),
    .pin_n    (ext_rst_n),
    .pin_en   (pin_rst_en),
    .pin_hold (pin_hold),
    .pin_evt  (evt_pin)
  );

  sysinit_fsm #(
    .POR_CYC   (POR_CYCLES),
    .STOP_LONG (STOP_LONG),
    .STOP_SHRT (STOP_SHORT)
  ) u_fsm (
    .clk_ref    (clk_ref),
    .por_req    (por_req),
    .int_src    ({bad_addr_rst, bad_op_rst, lvd_rst, wdog_rst}),
    .pin_hold   (pin_hold),
    .pin_evt    (evt_pin),
    .stop_req   (stop_req),
    .wake_irq   (wake_irq),
    .stop_short (stop_short),
    .phase      (phase),
    .tmo_cnt    (tmo_cnt),
    .rst_status (rst_status),
    .evt_int    (evt_int)
  );

  assign in_run  = (phase == PH_RUN);
  assign in_stop = (phase == PH_STOP);

  sysinit_busdiv #(.DIV(BUS_DIV)) u_div (
    .clk_ref (clk_ref),
    .por_req (por_req),
    .run     (in_run),
    .bus_ce  (bus_ce)
  );

  assign per_ce      = bus_ce;
  assign cpu_ce      = bus_ce & ~wait_req;
  assign int_rst     = (phase == PH_HOLD);
  assign vec_hi_addr = vec_high(monitor_mode);
  assign vec_lo_addr = vec_low(monitor_mode);
endmodule

// File: rtl/sysinit_ctrl_chk.sv
module sysinit_ctrl_chk #(
  parameter int CW = 12
) (
  input logic          clk_ref,
  input logic          por_req,
  input logic          int_rst,
  input logic          bus_ce,
  input logic          cpu_ce,
  input logic          per_ce,
  input logic          wait_req,
  input logic [5:0]    rst_status,
  input logic          evt_int,
  input logic          evt_pin,
  input logic          in_stop,
  input logic [CW-1:0] tmo_cnt,
  input logic [15:0]   vec_hi_addr,
  input logic [15:0]   vec_lo_addr
);
  localparam logic [CW-1:0] TC = {CW{1'b1}};

  assert_bus_spacing_R1: assert property (@(posedge clk_ref) disable iff (por_req)
    bus_ce |=> !bus_ce);
  assert_bus_quiet_in_reset_R1: assert property (@(posedge clk_ref) disable iff (por_req)
    per_ce |-> !int_rst);
  assert_release_at_tc_R2: assert property (@(posedge clk_ref) disable iff (por_req)
    $fell(int_rst) |-> ($past(tmo_cnt) == TC));
  assert_src_clears_R3: assert property (@(posedge clk_ref) disable iff (por_req)
    evt_int |=> (int_rst && tmo_cnt == '0));
  assert_pin_keeps_count_R4: assert property (@(posedge clk_ref) disable iff (por_req)
    (evt_pin && !evt_int) |=>
      (int_rst && (($past(tmo_cnt) == TC) ? (tmo_cnt == '0) : (tmo_cnt == $past(tmo_cnt) + CW'(1)))));
  assert_stop_quiet_R5: assert property (@(posedge clk_ref) disable iff (por_req)
    in_stop |-> (!per_ce && !cpu_ce && !int_rst));
  assert_wait_gates_cpu_R6: assert property (@(posedge clk_ref) disable iff (por_req)
    wait_req |-> !cpu_ce);
  assert_status_sticky_R7: assert property (@(posedge clk_ref) disable iff (por_req)
    (!evt_int && !evt_pin) |=> $stable(rst_status));
  assert_status_nonzero_R7: assert property (@(posedge clk_ref) disable iff (por_req)
    $countones(rst_status) != 0);
  assert_vector_pair_R8: assert property (@(posedge clk_ref) disable iff (por_req)
    (vec_lo_addr == vec_hi_addr + 16'd1) && (vec_hi_addr[7:0] == 8'hFE));
endmodule

bind sysinit_ctrl sysinit_ctrl_chk #(.CW(CW)) u_chk (
  .clk_ref     (clk_ref),
  .por_req     (por_req),
  .int_rst     (int_rst),
  .bus_ce      (bus_ce),
  .cpu_ce      (cpu_ce),
  .per_ce      (per_ce),
  .wait_req    (wait_req),
  .rst_status  (rst_status),
  .evt_int     (evt_int),
  .evt_pin     (evt_pin),
  .in_stop     (in_stop),
  .tmo_cnt     (tmo_cnt),
  .vec_hi_addr (vec_hi_addr),
  .vec_lo_addr (vec_lo_addr)
);

// File: tb/sysinit_ctrl_tb.sv
`timescale 1ns/1ps
module sysinit_ctrl_tb;
  localparam int TMO  = 4096;
  localparam int SSH  = 32;
  localparam int SLG  = 4096;
  localparam int PMIN = 67;
  localparam int DV   = 4;

  logic clk_ref = 1'b0;
  logic por_req = 1'b1;
  logic ext_rst_n = 1'b1, pin_rst_en = 1'b0;
  logic wdog_rst = 1'b0, lvd_rst = 1'b0, bad_op_rst = 1'b0, bad_addr_rst = 1'b0;
  logic stop_req = 1'b0, wake_irq = 1'b0, stop_short = 1'b0, wait_req = 1'b0, monitor_mode = 1'b0;
  logic bus_ce, cpu_ce, per_ce, int_rst;
  logic [5:0] rst_status;
  logic [15:0] vec_hi_addr, vec_lo_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk_ref = ~clk_ref;

  sysinit_ctrl u_dut (
    .clk_ref(clk_ref), .por_req(por_req), .ext_rst_n(ext_rst_n), .pin_rst_en(pin_rst_en),
    .wdog_rst(wdog_rst), .lvd_rst(lvd_rst), .bad_op_rst(bad_op_rst), .bad_addr_rst(bad_addr_rst),
    .stop_req(stop_req), .wake_irq(wake_irq), .stop_short(stop_short), .wait_req(wait_req),
    .monitor_mode(monitor_mode), .bus_ce(bus_ce), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .int_rst(int_rst), .rst_status(rst_status), .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr)
  );

  // Behavioural reference: 0 hold, 1 run, 2 stop, 3 stop delay
  int m_ph, m_cnt, m_div, m_lc, m_st;
  bit m_s1, m_s2, m_hq;

  always @(posedge clk_ref) begin
    if (por_req) begin
      m_ph = 0; m_cnt = 0; m_div = 0; m_lc = 0; m_st = 1;
      m_s1 = 1; m_s2 = 1; m_hq = 0;
    end else begin
      bit low, hold, evp, evi, wake_ok;
      int ints, nph, ncnt;
      low  = !m_s2 && pin_rst_en;
      hold = low && (m_lc == PMIN - 1);
      evp  = hold && !m_hq;
      ints = {bad_addr_rst, bad_op_rst, lvd_rst, wdog_rst};
      evi  = (ints != 0);
      wake_ok = (m_ph == 2) && wake_irq && !evp && !evi;
      if (evi || wake_ok) ncnt = 0;
      else ncnt = (m_cnt + 1) % TMO;
      nph = m_ph;
      if (evi || evp) nph = 0;
      else if (m_ph == 0 && m_cnt == TMO - 1 && !hold) nph = 1;
      else if (m_ph == 1 && stop_req) nph = 2;
      else if (m_ph == 2 && wake_irq) nph = 3;
      else if (m_ph == 3 && m_cnt == (stop_short ? SSH : SLG) - 1) nph = 1;
      if (evi || evp) m_st = (ints << 2) | (evp ? 2 : 0);
      m_div = (m_ph == 1) ? (m_div + 1) % DV : 0;
      m_lc  = low ? ((m_lc < PMIN - 1) ? m_lc + 1 : m_lc) : 0;
      m_hq  = hold;
      m_s2  = m_s1;
      m_s1  = ext_rst_n;
      m_ph  = nph;
      m_cnt = ncnt;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk_ref) begin
    if (!por_req) begin
      bit eb;
      eb = (m_ph == 1) && (m_div == DV - 1);
      check("R1", "bus_ce", bus_ce, eb);
      check("R1", "per_ce", per_ce, eb);
      check("R6", "cpu_ce", cpu_ce, eb && !wait_req);
      check("R2", "int_rst", int_rst, m_ph == 0);
      check("R7", "rst_status", rst_status, m_st);
      check("R8", "vec_hi_addr", vec_hi_addr, monitor_mode ? 16'hFEFE : 16'hFFFE);
      check("R8", "vec_lo_addr", vec_lo_addr, monitor_mode ? 16'hFEFF : 16'hFFFF);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk_ref); #2;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    do begin tick(); n++; end while (int_rst && n < 20000);
  endtask

  task automatic count_to_bus(output int n);
    n = 0;
    do begin tick(); n++; end while (!per_ce && n < 20000);
  endtask

  initial begin
    int n, pc, cc;
    bit seen;
    repeat (3) tick();
    // R2, R7: state held during power-on
    check("R2", "int_rst in por", int_rst, 1);
    check("R2", "per_ce in por", per_ce, 0);
    check("R7", "status after por", rst_status, 6'b000001);
    por_req = 1'b0;
    wait_release(n);
    check("R2", "por release edges", n, TMO);

    // R1: pulse spacing in run
    pc = 0;
    repeat (40) begin tick(); pc += per_ce; end
    check("R1", "bus pulses in 40 cycles", pc, 10);

    // R6: wait gates only the CPU
    wait_req = 1'b1; pc = 0; cc = 0;
    repeat (20) begin tick(); pc += per_ce; cc += cpu_ce; end
    check("R6", "per_ce pulses in wait", pc, 5);
    check("R6", "cpu_ce pulses in wait", cc, 0);
    wait_req = 1'b0;

    // R8: monitor vector
    monitor_mode = 1'b1; #1;
    check("R8", "monitor vec hi", vec_hi_addr, 16'hFEFE);
    check("R8", "monitor vec lo", vec_lo_addr, 16'hFEFF);
    monitor_mode = 1'b0;

    // R3: single-cycle watchdog request
    tick();
    wdog_rst = 1'b1; tick(); wdog_rst = 1'b0;
    check("R3", "int_rst after watchdog", int_rst, 1);
    check("R7", "status after watchdog", rst_status, 6'b000100);
    wait_release(n);
    check("R3", "watchdog release edges", n, TMO);

    // R7: two causes in the same cycle
    lvd_rst = 1'b1; bad_op_rst = 1'b1; tick(); lvd_rst = 1'b0; bad_op_rst = 1'b0;
    check("R7", "status two causes", rst_status, 6'b011000);
    wait_release(n);

    // R4: pin ignored while disabled
    pin_rst_en = 1'b0; ext_rst_n = 1'b0; seen = 0;
    repeat (120) begin tick(); seen |= int_rst; end
    ext_rst_n = 1'b1;
    check("R4", "pin disabled reset", seen, 0);
    check("R4", "status untouched (disabled)", rst_status, 6'b011000);

    // R4: pin pulse shorter than the minimum
    pin_rst_en = 1'b1; ext_rst_n = 1'b0; seen = 0;
    repeat (PMIN - 10) begin tick(); seen |= int_rst; end
    ext_rst_n = 1'b1;
    repeat (10) begin tick(); seen |= int_rst; end
    check("R4", "short pin reset", seen, 0);

    // R4: long pin pulse
    ext_rst_n = 1'b0;
    repeat (PMIN + 30) tick();
    check("R4", "int_rst after long pin", int_rst, 1);
    check("R7", "status after pin", rst_status, 6'b000010);
    ext_rst_n = 1'b1;
    wait_release(n);
    check("R4", "pin hold ended", int_rst, 0);

    // R5: stop, then short wake
    tick(); stop_req = 1'b1; tick(); stop_req = 1'b0;
    pc = 0; seen = 0;
    repeat (40) begin tick(); pc += per_ce; seen |= int_rst; end
    check("R5", "enables in stop", pc, 0);
    check("R5", "int_rst in stop", seen, 0);
    stop_short = 1'b1; wake_irq = 1'b1; tick(); wake_irq = 1'b0;
    count_to_bus(n);
    check("R5", "short wake to bus_ce", n, SSH + DV - 1);

    // R5: long wake
    stop_req = 1'b1; tick(); stop_req = 1'b0; repeat (5) tick();
    stop_short = 1'b0; wake_irq = 1'b1; tick(); wake_irq = 1'b0;
    count_to_bus(n);
    check("R5", "long wake to bus_ce", n, SLG + DV - 1);

    // R9: reset source during stop and during the delay
    stop_req = 1'b1; tick(); stop_req = 1'b0; repeat (3) tick();
    bad_addr_rst = 1'b1; tick(); bad_addr_rst = 1'b0;
    check("R9", "reset from stop", int_rst, 1);
    check("R7", "status illegal address", rst_status, 6'b100000);
    wait_release(n);
    check("R9", "release after stop reset", n, TMO);
    stop_req = 1'b1; tick(); stop_req = 1'b0; tick();
    stop_short = 1'b0; wake_irq = 1'b1; tick(); wake_irq = 1'b0; repeat (10) tick();
    lvd_rst = 1'b1; tick(); lvd_rst = 1'b0;
    check("R9", "reset from stop delay", int_rst, 1);
    wait_release(n);
    check("R9", "release after delay reset", n, TMO);

    repeat (8) tick();
    summary();
    $finish;
  end
endmodule